// File: doc/BRIEF.md
# Interrupt Source Routing Controller

This block gathers forty level-sensitive interrupt lines and sends each one to one of two processor request outputs: a fast request or a normal request. Software selects which sources take part through an enable mask. A per-source route bit chooses which output the source drives. A separate idle mask lets sources that are masked off still wake a halted core. Sources are held in two register banks. The low bank is 32 bits wide and the high bank holds the remaining eight. A source sits at the bit position given by its number modulo 32.

Software reaches the block through a plain 32-bit register bus with separate read and write strobes. Writes take effect on the clock edge. Read data is registered and appears one cycle after the read strobe. The block keeps one priority word per source and exports all of them to an external priority resolver. The resolver's result is read back through one register. The resolver logic itself is outside this block.

Top module: `intr_route_ctrl`

## Requirements
- R1: Source n (0..31) occupies bit n of the low bank. Source n (32..39) occupies bit n-32 of the high bank. In the high bank, bits 8 and up read 0.
- R2: The raw pending register holds the input level captured at each clock edge, with no latching. It is at offset 0x10 for the low bank and 0xAC for the high bank. A source that drops low reads 0 after the next edge.
- R3: A route bit of 1 sends its source to fiqOut and 0 sends it to irqOut. fiqOut is 1 when any source is high, enabled and routed to the fast output. irqOut is 1 when any source is high, enabled and routed to the normal output.
- R4: wakeOut is 1 when cpuHalted is high and some high source is either enabled or covered by the idle mask. It is 0 while cpuHalted is low.
- R5: Bit 0 of the control register (0x14) sets the idle mask. Writing 0 sets the idle mask to all ones and writing 1 sets it to all zeros. A read returns 1 when the idle mask is zero and 0 otherwise. After reset the idle mask is zero, so the read returns 1.
- R6: The filtered views return pending AND enabled AND route==0 for the normal output, at 0x00 (low bank) and 0x9C (high bank). They return pending AND enabled AND route==1 for the fast output, at 0x0C (low bank) and 0xA8 (high bank).
- R7: The enable masks are at 0x04 and 0xA0, and the route selects are at 0x08 and 0xA4. They read back what was written, keep only the implemented source bits, and reset to zero.
- R8: The raw pending registers and the filtered views are read-only. Writes to them change no state.
- R9: A read of an unmapped or misaligned offset returns 0. A write to one has no effect.
- R10: Priority word i is at 0x1C+4i for i<32 and at 0xB0+4(i-32) for i>=32. It keeps only bit 31 (valid) and bits 5:0 (source id), and reads back in those positions. It appears on prioCfg[7i+6 : 7i] as {valid, id}. Offset 0x18 returns the prioResult input.
- R11: irqOut, fiqOut and wakeOut are registered. They take their new value on the first clock edge after an input or register change. rdData is valid in the cycle after rdEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcLevel | input | 40 | Interrupt source levels |
| cpuHalted | input | 1 | Processor is halted |
| regAddr | input | 8 | Register byte offset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, one cycle after rdEn |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| wakeOut | output | 1 | Wake request for halted core |
| prioCfg | output | 280 | Priority words to the resolver, 7 bits each |
| prioResult | input | 32 | Resolver result returned at offset 0x18 |

## Verification
A source change or register write driven at a falling edge shows on irqOut, fiqOut and wakeOut at the following rising edge. The bench samples these outputs at the next falling edge. One bench check samples half a cycle earlier and confirms the old value still holds at that point. A read issued at a falling edge has its data latched at the next rising edge. The driver therefore queues the expected word when it issues the read. The monitor pops and compares the word at the falling edge after the rising edge on which rdEn was seen.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned IRC_BANK_W = 32;
  localparam int unsigned IRC_IDX_W  = 6;
  localparam int unsigned IRC_PRIO_W = 7;

  typedef enum logic [3:0] {
    RD_ZERO, RD_IRQV_LO, RD_MASK_LO, RD_ROUTE_LO, RD_FIQV_LO, RD_RAW_LO,
    RD_CTRL, RD_PRIRES, RD_PRIO, RD_IRQV_HI, RD_MASK_HI, RD_ROUTE_HI,
    RD_FIQV_HI, RD_RAW_HI
  } rdSel_e;

  typedef struct packed {
    logic                 wrMaskLo;
    logic                 wrMaskHi;
    logic                 wrRouteLo;
    logic                 wrRouteHi;
    logic                 wrCtrl;
    logic                 wrPrio;
    logic [IRC_IDX_W-1:0] prioIdx;
    rdSel_e               rdSel;
  } ircStrobe_t;
endpackage

// File: rtl/irc_ctrl.sv
module irc_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output ircStrobe_t        st
);
  localparam int HI_CNT     = int'(NUM_SRC) - 32;
  localparam int A_IRQV_LO  = 'h00;
  localparam int A_MASK_LO  = 'h04;
  localparam int A_ROUTE_LO = 'h08;
  localparam int A_FIQV_LO  = 'h0C;
  localparam int A_RAW_LO   = 'h10;
  localparam int A_CTRL     = 'h14;
  localparam int A_PRIRES   = 'h18;
  localparam int A_PRIO_LO  = 'h1C;
  localparam int A_IRQV_HI  = 'h9C;
  localparam int A_MASK_HI  = 'hA0;
  localparam int A_ROUTE_HI = 'hA4;
  localparam int A_FIQV_HI  = 'hA8;
  localparam int A_RAW_HI   = 'hAC;
  localparam int A_PRIO_HI  = 'hB0;

  int     addrInt;
  rdSel_e sel;
  logic   isPrio;
  int     prioNum;

  always_comb begin
    addrInt = int'({{(32 - ADDR_W){1'b0}}, regAddr});
    isPrio  = 1'b0;
    prioNum = 0;
    sel     = RD_ZERO;
    if (addrInt[1:0] == 2'b00) begin
      if (addrInt >= A_PRIO_LO && addrInt < A_PRIO_LO + 4 * 32) begin
        isPrio  = 1'b1;
        prioNum = (addrInt - A_PRIO_LO) / 4;
      end else if (addrInt >= A_PRIO_HI && addrInt < A_PRIO_HI + 4 * HI_CNT) begin
        isPrio  = 1'b1;
        prioNum = 32 + (addrInt - A_PRIO_HI) / 4;
      end
      case (addrInt)
        A_IRQV_LO:  sel = RD_IRQV_LO;
        A_MASK_LO:  sel = RD_MASK_LO;
        A_ROUTE_LO: sel = RD_ROUTE_LO;
        A_FIQV_LO:  sel = RD_FIQV_LO;
        A_RAW_LO:   sel = RD_RAW_LO;
        A_CTRL:     sel = RD_CTRL;
        A_PRIRES:   sel = RD_PRIRES;
        A_IRQV_HI:  sel = RD_IRQV_HI;
        A_MASK_HI:  sel = RD_MASK_HI;
        A_ROUTE_HI: sel = RD_ROUTE_HI;
        A_FIQV_HI:  sel = RD_FIQV_HI;
        A_RAW_HI:   sel = RD_RAW_HI;
        default:    sel = isPrio ? RD_PRIO : RD_ZERO;
      endcase
    end
  end

  always_comb begin
    st           = '0;
    st.rdSel     = rdEn ? sel : RD_ZERO;
    st.prioIdx   = IRC_IDX_W'(prioNum);
    st.wrMaskLo  = wrEn && (sel == RD_MASK_LO);
    st.wrMaskHi  = wrEn && (sel == RD_MASK_HI);
    st.wrRouteLo = wrEn && (sel == RD_ROUTE_LO);
    st.wrRouteHi = wrEn && (sel == RD_ROUTE_HI);
    st.wrCtrl    = wrEn && (sel == RD_CTRL);
    st.wrPrio    = wrEn && isPrio;
  end

  // R9: at most one state write strobe per cycle
  p_single_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrMaskLo, st.wrMaskHi, st.wrRouteLo, st.wrRouteHi, st.wrCtrl, st.wrPrio}));
  // R8: no write strobe without a bus write
  p_no_wr_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(st.wrMaskLo || st.wrMaskHi || st.wrRouteLo || st.wrRouteHi || st.wrCtrl || st.wrPrio));
  // R10: priority index in range
  p_prio_idx_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.wrPrio |-> (int'(st.prioIdx) < int'(NUM_SRC)));
endmodule

// File: rtl/irc_datapath.sv
module irc_datapath
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ircStrobe_t                    st,
  input  logic [31:0]                   wrData,
  input  logic                          rdEn,
  input  logic [NUM_SRC-1:0]            srcLevel,
  input  logic                          cpuHalted,
  input  logic [31:0]                   prioResult,
  output logic [31:0]                   rdData,
  output logic                          irqOut,
  output logic                          fiqOut,
  output logic                          wakeOut,
  output logic [NUM_SRC*IRC_PRIO_W-1:0] prioCfg
);
  localparam int unsigned HI_W = NUM_SRC - IRC_BANK_W;

  logic [IRC_BANK_W-1:0] maskLo, routeLo, maskLoN, routeLoN;
  logic [HI_W-1:0]       maskHi, routeHi, maskHiN, routeHiN;
  logic                  idleOn, idleN;
  logic [NUM_SRC-1:0]    pendReg, maskAll, routeAll, maskAllN, routeAllN;
  logic [NUM_SRC-1:0]    irqView, fiqView;
  logic [IRC_PRIO_W-1:0] prioVal [NUM_SRC];
  logic [IRC_PRIO_W-1:0] prioRd;
  logic [31:0]           rdNext;
  logic                  armed;

  always_comb begin
    maskLoN   = st.wrMaskLo  ? wrData : maskLo;
    maskHiN   = st.wrMaskHi  ? wrData[HI_W-1:0] : maskHi;
    routeLoN  = st.wrRouteLo ? wrData : routeLo;
    routeHiN  = st.wrRouteHi ? wrData[HI_W-1:0] : routeHi;
    idleN     = st.wrCtrl    ? ~wrData[0] : idleOn;
    maskAllN  = {maskHiN, maskLoN};
    routeAllN = {routeHiN, routeLoN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLo  <= '0;
      maskHi  <= '0;
      routeLo <= '0;
      routeHi <= '0;
      idleOn  <= 1'b0;
      pendReg <= '0;
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
      wakeOut <= 1'b0;
      armed   <= 1'b0;
    end else begin
      maskLo  <= maskLoN;
      maskHi  <= maskHiN;
      routeLo <= routeLoN;
      routeHi <= routeHiN;
      idleOn  <= idleN;
      pendReg <= srcLevel;
      irqOut  <= |(srcLevel & maskAllN & ~routeAllN);
      fiqOut  <= |(srcLevel & maskAllN & routeAllN);
      wakeOut <= cpuHalted && |(srcLevel & (maskAllN | {NUM_SRC{idleN}}));
      armed   <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioVal[i] <= '0;
      else if (st.wrPrio && (st.prioIdx == IRC_IDX_W'(i)))
        prioVal[i] <= {wrData[31], wrData[5:0]};
    end
    assign prioCfg[i*IRC_PRIO_W +: IRC_PRIO_W] = prioVal[i];
  end

  always_comb begin
    prioRd = '0;
    for (int i = 0; i < int'(NUM_SRC); i++)
      if (st.prioIdx == IRC_IDX_W'(i)) prioRd = prioVal[i];
  end

  assign maskAll  = {maskHi, maskLo};
  assign routeAll = {routeHi, routeLo};
  assign irqView  = pendReg & maskAll & ~routeAll;
  assign fiqView  = pendReg & maskAll & routeAll;

  always_comb begin
    case (st.rdSel)
      RD_IRQV_LO:  rdNext = irqView[IRC_BANK_W-1:0];
      RD_MASK_LO:  rdNext = maskLo;
      RD_ROUTE_LO: rdNext = routeLo;
      RD_FIQV_LO:  rdNext = fiqView[IRC_BANK_W-1:0];
      RD_RAW_LO:   rdNext = pendReg[IRC_BANK_W-1:0];
      RD_CTRL:     rdNext = {31'b0, ~idleOn};
      RD_PRIRES:   rdNext = prioResult;
      RD_PRIO:     rdNext = {prioRd[6], 25'b0, prioRd[5:0]};
      RD_IRQV_HI:  rdNext = 32'(irqView[NUM_SRC-1:IRC_BANK_W]);
      RD_MASK_HI:  rdNext = 32'(maskHi);
      RD_ROUTE_HI: rdNext = 32'(routeHi);
      RD_FIQV_HI:  rdNext = 32'(fiqView[NUM_SRC-1:IRC_BANK_W]);
      RD_RAW_HI:   rdNext = 32'(pendReg[NUM_SRC-1:IRC_BANK_W]);
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  // R2: raw pending tracks the input level of the previous edge
  p_pend_follow_r2: assert property (@(posedge clk) disable iff (!rstN || !armed)
    pendReg == $past(srcLevel));
  // R3: request outputs agree with registered state
  p_irq_state_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |irqView);
  p_fiq_state_r3: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut == |fiqView);
  // R4: wake only follows a halted cycle
  p_wake_halt_r4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    wakeOut |-> $past(cpuHalted));
  // R8: mask changes only through its own write strobe
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrMaskLo || st.wrMaskHi) |=> $stable(maskAll));
  // R11: read data holds when no read is issued
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

// File: rtl/intr_route_ctrl.sv
module intr_route_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            srcLevel,
  input  logic                          cpuHalted,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          wrEn,
  input  logic [31:0]                   wrData,
  input  logic                          rdEn,
  output logic [31:0]                   rdData,
  output logic                          irqOut,
  output logic                          fiqOut,
  output logic                          wakeOut,
  output logic [NUM_SRC*IRC_PRIO_W-1:0] prioCfg,
  input  logic [31:0]                   prioResult
);
  ircStrobe_t strobes;

  irc_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn), .st(strobes)
  );

  irc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .wrData(wrData), .rdEn(rdEn),
    .srcLevel(srcLevel), .cpuHalted(cpuHalted), .prioResult(prioResult),
    .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut), .wakeOut(wakeOut),
    .prioCfg(prioCfg)
  );
endmodule

// File: tb/test_intr_route_ctrl.sv
`timescale 1ns/100ps
module test_intr_route_ctrl;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [39:0]  srcLevel = '0;
  logic         cpuHalted = 1'b0;
  logic [7:0]   regAddr = '0;
  logic         wrEn = 1'b0;
  logic [31:0]  wrData = '0;
  logic         rdEn = 1'b0;
  logic [31:0]  rdData;
  logic         irqOut, fiqOut, wakeOut;
  logic [279:0] prioCfg;
  logic [31:0]  prioResult = 32'h1234_5678;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        issued = 1'b0;

  always #2.5 clk = ~clk;

  intr_route_ctrl i_intr_route_ctrl (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .cpuHalted(cpuHalted),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .irqOut(irqOut), .fiqOut(fiqOut), .wakeOut(wakeOut), .prioCfg(prioCfg),
    .prioResult(prioResult)
  );

  // monitor: compares read data against the queued expectation
  always @(posedge clk) issued <= rdEn;
  always @(negedge clk) begin
    if (issued) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL %s: unexpected read data %h, expected none", "R11", rdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          failures++;
          $display("FAIL %s: read got %h expected %h", t, rdData, e);
        end
      end
    end
  end

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rdEn = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setSrc(input logic [39:0] v);
    @(negedge clk);
    srcLevel = v;
    @(negedge clk);
  endtask

  task automatic chkOut(input string t, input logic [2:0] e);
    checks++;
    if ({irqOut, fiqOut, wakeOut} !== e) begin
      failures++;
      $display("FAIL %s: irq/fiq/wake got %b expected %b", t, {irqOut, fiqOut, wakeOut}, e);
    end
  endtask

  task automatic chkVal(input string t, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s: got %h expected %h", t, a, e);
    end
  endtask

  initial begin
    #5000000;
    failures++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkOut("R11 reset", 3'b000);
    doRead(8'h14, 32'h1, "R5 reset ctrl");
    doRead(8'h04, 32'h0, "R7 reset mask");
    doRead(8'h08, 32'h0, "R7 reset route");

    // low bank routing
    doWrite(8'h04, 32'h0000_00F0);
    doWrite(8'h08, 32'h0000_0030);
    doRead(8'h04, 32'h0000_00F0, "R7 mask lo");
    setSrc(40'h10);
    chkOut("R3 fast route", 3'b010);
    setSrc(40'h50);
    chkOut("R3 both routes", 3'b110);
    doRead(8'h00, 32'h40, "R6 irq view lo");
    doRead(8'h0C, 32'h10, "R6 fiq view lo");
    doRead(8'h10, 32'h50, "R2 raw lo");
    setSrc(40'h40);
    chkOut("R2 drop no latch", 3'b100);
    doRead(8'h10, 32'h40, "R2 raw after drop");
    setSrc(40'h0F);
    chkOut("R3 disabled sources", 3'b000);
    doRead(8'h10, 32'h0F, "R2 raw disabled");

    // R11: change lands on the next edge, not before
    @(negedge clk);
    srcLevel = 40'h80;
    #1 chkOut("R11 before edge", 3'b000);
    @(negedge clk);
    chkOut("R11 after edge", 3'b100);
    setSrc(40'h0);

    // high bank
    doWrite(8'hA0, 32'hFFFF_FFFF);
    doRead(8'hA0, 32'h0000_00FF, "R7 mask hi width");
    doWrite(8'hA4, 32'h0000_0008);
    doRead(8'hA4, 32'h0000_0008, "R7 route hi");
    setSrc(40'h08_0000_0000);
    chkOut("R1 source 35 fast", 3'b010);
    doRead(8'hA8, 32'h08, "R1 fiq view hi");
    doRead(8'hAC, 32'h08, "R1 raw hi");
    doRead(8'h10, 32'h0, "R1 low bank clear");
    setSrc(40'h10_0000_0000);
    chkOut("R1 source 36 normal", 3'b100);
    doRead(8'h9C, 32'h10, "R6 irq view hi");

    // wake
    doWrite(8'hA0, 32'h0);
    cpuHalted = 1'b1;
    setSrc(40'h10_0000_0000);
    chkOut("R4 masked no idle", 3'b000);
    doWrite(8'h14, 32'h0);
    chkOut("R4 idle mask wakes", 3'b001);
    doRead(8'h14, 32'h0, "R5 ctrl idle on");
    doWrite(8'h14, 32'h1);
    chkOut("R4 idle mask off", 3'b000);
    doRead(8'h14, 32'h1, "R5 ctrl idle off");
    doWrite(8'hA0, 32'h10);
    chkOut("R4 enabled wakes", 3'b101);
    @(negedge clk);
    cpuHalted = 1'b0;
    @(negedge clk);
    chkOut("R4 not halted", 3'b100);

    // read-only and unmapped
    doWrite(8'hAC, 32'hFFFF_FFFF);
    doWrite(8'h00, 32'hFFFF_FFFF);
    doWrite(8'h9C, 32'hFFFF_FFFF);
    doRead(8'hAC, 32'h10, "R8 raw hi unchanged");
    doRead(8'h04, 32'h0000_00F0, "R8 mask lo unchanged");
    doRead(8'hA0, 32'h10, "R8 mask hi unchanged");
    doWrite(8'hD0, 32'hFFFF_FFFF);
    doWrite(8'h05, 32'hFFFF_FFFF);
    doRead(8'h08, 32'h30, "R9 route lo unchanged");
    doRead(8'hD0, 32'h0, "R9 unmapped read");
    doRead(8'h05, 32'h0, "R9 misaligned read");
    doRead(8'hFC, 32'h0, "R9 top read");
    chkVal("R9 prio untouched", 32'(prioCfg[279:273]), 32'h0);

    // priority words
    doWrite(8'h24, 32'hFFFF_FFFF);
    doRead(8'h24, 32'h8000_003F, "R10 prio 2 masked");
    chkVal("R10 prio 2 export", 32'(prioCfg[20:14]), 32'h7F);
    doWrite(8'hCC, 32'h8000_0025);
    doRead(8'hCC, 32'h8000_0025, "R10 prio 39");
    chkVal("R10 prio 39 export", 32'(prioCfg[279:273]), 32'h65);
    doRead(8'h18, 32'h1234_5678, "R10 resolver result");

    repeat (3) @(negedge clk);
    chkVal("R11 queue drained", 32'(expQ.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule